// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Two Compare Channels

This block holds an 8-bit count register that moves only when a one-cycle timer tick strobe arrives and a nonzero clock-select field lets it run. A two-bit mode field picks between counting up, counting down, counting up with a restart when the count equals compare value A, and holding the count at zero. A host register port reads and writes the count, both compare values, a control register and a flag register. A write to the count always beats whatever the tick would have done in that cycle.

Each of the two compare channels sets a sticky flag on a running tick when the count equals its compare value. The flag therefore becomes visible in the cycle after that tick. It raises an interrupt request while its enable bit is set. An overflow flag records count wrap-around in the same way. Every flag clears through its own acknowledge input or when the host writes a one to its bit. A flag set in the same cycle as a clear wins over the clear. Registered "count at maximum" and "count at zero" indications are exported for a later waveform stage.

Top module: `tmr_dual_cmp`

## Requirements
- R1: After synchronous reset, all registers read zero, `at_bottom` is 1, `at_max` is 0 and `irq` is 0.
- R2: With clock select (control bits 2:0) equal to zero, ticks leave the count unchanged, and the host can still write and read the count.
- R3: Mode 00 (control bits 4:3) adds one to the count on each running tick and wraps 0xFF to 0x00. Without a tick the count holds.
- R4: Mode 01 subtracts one on each running tick. The wrap from 0x00 to 0xFF sets the overflow flag (flag bit 2).
- R5: Mode 10 counts up but loads zero on a running tick where the count equals compare A. Mode 11 loads zero on every running tick.
- R6: A host write to the count (address 0) takes effect even when a running tick arrives in the same cycle.
- R7: Compare A (address 1) and compare B (address 2) set flag bit 0 and flag bit 1 on a running tick where the count equals them. Equality without a running tick sets nothing.
- R8: `irq` bit 0, 1 and 2 are flag A, flag B and overflow, each ANDed with its enable: control bit 5, 6 and 7.
- R9: A flag clears when its `irq_ack` bit is pulsed, or when the host writes a one to its bit of the flag register (address 4). Writing a zero leaves it unchanged.
- R10: If a flag's set event and its clear occur in the same cycle, the flag ends up set.
- R11: `at_max` is 1 exactly when the count is 0xFF, and `at_bottom` exactly when it is 0x00.
- R12: In mode 00, the running tick that wraps 0xFF to 0x00 sets the overflow flag.
- R13: Register reads are addressed by `host_raddr` and appear on `host_rdata` one cycle later. Address 3 is the control register, address 4 holds the flags in bits 2:0, and addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timer clock enable strobe |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 3 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 3 | Host read address |
| host_rdata | output | 8 | Registered read data, one cycle latency |
| irq_ack | input | 3 | Interrupt acknowledge: bit0 A, bit1 B, bit2 overflow |
| irq | output | 3 | Interrupt requests: bit0 A, bit1 B, bit2 overflow |
| at_max | output | 1 | Count equals 0xFF |
| at_bottom | output | 1 | Count equals 0x00 |

## Verification
Two pairs of events can land in one cycle. A host count write can meet a running tick, and a compare flag's set event can meet its write-one clear. The bench provokes both by driving the tick strobe and the host write on the same clock edge. For the first pair it reads back the count and expects the written value, not the incremented one. For the second it reads the flag register and expects the flag still set, with the count stepped by one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_UP    = 2'b00,
    MODE_DOWN  = 2'b01,
    MODE_CLR_A = 2'b10,
    MODE_HOLD  = 2'b11
  } tmr_mode_e;

  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned N_CMP    = 2;
  localparam int unsigned N_FLAG   = N_CMP + 1;

  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;

  typedef struct packed {
    logic      ie_ovf;
    logic      ie_b;
    logic      ie_a;
    tmr_mode_e mode;
    logic [2:0] csel;
  } tmr_ctrl_t;

endpackage

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic ack,
  input  logic w1c,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (rst)            flag_q <= 1'b0;
    else if (set_evt)   flag_q <= 1'b1;
    else if (ack | w1c) flag_q <= 1'b0;
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  tmr_mode_e    mode,
  input  logic         match_a,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_q,
  output logic         wrap_evt,
  output logic         at_max,
  output logic         at_bottom
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_d;
  logic         wrap_d;

  always_comb begin
    cnt_d  = count_q;
    wrap_d = 1'b0;
    if (wr_en) begin
      cnt_d = wr_data;
    end else if (run) begin
      unique case (mode)
        MODE_UP: begin
          cnt_d  = count_q + ONE;
          wrap_d = (count_q == MAXV);
        end
        MODE_DOWN: begin
          cnt_d  = count_q - ONE;
          wrap_d = (count_q == ZERO);
        end
        MODE_CLR_A: begin
          cnt_d  = match_a ? ZERO : count_q + ONE;
          wrap_d = (count_q == MAXV);
        end
        default: begin
          cnt_d = ZERO;
        end
      endcase
    end
  end

  assign wrap_evt = wrap_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= ZERO;
      at_max    <= 1'b0;
      at_bottom <= 1'b1;
    end else begin
      count_q   <= cnt_d;
      at_max    <= (cnt_d == MAXV);
      at_bottom <= (cnt_d == ZERO);
    end
  end

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] count,
  input  logic         run,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         ack,
  input  logic         w1c,
  output logic [W-1:0] cmp_q,
  output logic         match,
  output logic         flag_q
);

  always_ff @(posedge clk) begin
    if (rst)         cmp_q <= '0;
    else if (cmp_wr) cmp_q <= cmp_wdata;
  end

  assign match = (count == cmp_q);

  tmr_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .set_evt (run & match),
    .ack     (ack),
    .w1c     (w1c),
    .flag_q  (flag_q)
  );

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [W-1:0]      host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  input  logic [W-1:0]      count,
  input  logic [W-1:0]      cmp_a,
  input  logic [W-1:0]      cmp_b,
  input  logic [N_FLAG-1:0] flags,
  output tmr_ctrl_t         ctrl_q,
  output logic              cnt_wr,
  output logic [N_CMP-1:0]  cmp_wr,
  output logic [N_FLAG-1:0] flag_w1c,
  output logic [W-1:0]      host_rdata
);

  logic flg_wr;

  assign cnt_wr    = host_we && (host_waddr == A_COUNT);
  assign cmp_wr[0] = host_we && (host_waddr == A_CMPA);
  assign cmp_wr[1] = host_we && (host_waddr == A_CMPB);
  assign flg_wr    = host_we && (host_waddr == A_FLAGS);
  assign flag_w1c  = flg_wr ? host_wdata[N_FLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (host_we && host_waddr == A_CTRL) ctrl_q <= tmr_ctrl_t'(host_wdata[7:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      unique case (host_raddr)
        A_COUNT: host_rdata <= count;
        A_CMPA:  host_rdata <= cmp_a;
        A_CMPB:  host_rdata <= cmp_b;
        A_CTRL:  host_rdata <= W'(ctrl_q);
        A_FLAGS: host_rdata <= W'(flags);
        default: host_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_dual_cmp.sv
module tmr_dual_cmp
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [W-1:0]      host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [W-1:0]      host_rdata,
  input  logic [N_FLAG-1:0] irq_ack,
  output logic [N_FLAG-1:0] irq,
  output logic              at_max,
  output logic              at_bottom
);

  tmr_ctrl_t           ctrl_q;
  logic                run;
  logic                cnt_wr;
  logic [N_CMP-1:0]    cmp_wr;
  logic [N_FLAG-1:0]   flag_w1c;
  logic [N_FLAG-1:0]   flags;
  logic [W-1:0]        count_q;
  logic [W-1:0]        cmp_q [N_CMP];
  logic [N_CMP-1:0]    match;
  logic                wrap_evt;
  logic [N_FLAG-1:0]   irq_en;

  assign run = tick && (ctrl_q.csel != 3'd0);

  tmr_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_waddr (host_waddr),
    .host_wdata (host_wdata),
    .host_raddr (host_raddr),
    .count      (count_q),
    .cmp_a      (cmp_q[0]),
    .cmp_b      (cmp_q[1]),
    .flags      (flags),
    .ctrl_q     (ctrl_q),
    .cnt_wr     (cnt_wr),
    .cmp_wr     (cmp_wr),
    .flag_w1c   (flag_w1c),
    .host_rdata (host_rdata)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .mode      (ctrl_q.mode),
    .match_a   (match[0]),
    .wr_en     (cnt_wr),
    .wr_data   (host_wdata),
    .count_q   (count_q),
    .wrap_evt  (wrap_evt),
    .at_max    (at_max),
    .at_bottom (at_bottom)
  );

  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    tmr_cmp_chan #(.W(W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .count     (count_q),
      .run       (run),
      .cmp_wr    (cmp_wr[c]),
      .cmp_wdata (host_wdata),
      .ack       (irq_ack[c]),
      .w1c       (flag_w1c[c]),
      .cmp_q     (cmp_q[c]),
      .match     (match[c]),
      .flag_q    (flags[c])
    );
  end

  tmr_flag u_ovf (
    .clk     (clk),
    .rst     (rst),
    .set_evt (wrap_evt),
    .ack     (irq_ack[N_CMP]),
    .w1c     (flag_w1c[N_CMP]),
    .flag_q  (flags[N_CMP])
  );

  assign irq_en = {ctrl_q.ie_ovf, ctrl_q.ie_b, ctrl_q.ie_a};
  assign irq    = flags & irq_en;

endmodule

// File: rtl/tmr_dual_cmp_chk.sv
module tmr_dual_cmp_chk
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_waddr,
  input logic [W-1:0]      host_wdata,
  input logic [N_FLAG-1:0] irq_ack,
  input tmr_ctrl_t         ctrl_q,
  input logic [W-1:0]      count_q,
  input logic [W-1:0]      cmp_a,
  input logic [N_FLAG-1:0] flags
);

  logic cw;
  logic running;
  assign cw      = host_we && (host_waddr == A_COUNT);
  assign running = tick && (ctrl_q.csel != 3'd0);

  p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
    cw |=> count_q == $past(host_wdata));

  p_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (!cw && ctrl_q.csel == 3'd0) |=> $stable(count_q));

  p_up_step_r3: assert property (@(posedge clk) disable iff (rst)
    (running && ctrl_q.mode == MODE_UP && !cw) |=> count_q == W'($past(count_q) + 1'b1));

  p_match_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (running && count_q == cmp_a) |=> flags[0]);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[0] && !running) |=> !flags[0]);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flags[1] && !irq_ack[1] && !(host_we && host_waddr == A_FLAGS && host_wdata[1])) |=> flags[1]);

endmodule

bind tmr_dual_cmp tmr_dual_cmp_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .host_we    (host_we),
  .host_waddr (host_waddr),
  .host_wdata (host_wdata),
  .irq_ack    (irq_ack),
  .ctrl_q     (ctrl_q),
  .count_q    (count_q),
  .cmp_a      (cmp_q[0]),
  .flags      (flags)
);

// File: tb/test_tmr_dual_cmp.sv
`timescale 1ns/1ps
module test_tmr_dual_cmp;

  logic       clk = 1'b0;
  logic       rst;
  logic       tick;
  logic       host_we;
  logic [2:0] host_waddr;
  logic [7:0] host_wdata;
  logic [2:0] host_raddr;
  logic [7:0] host_rdata;
  logic [2:0] irq_ack;
  logic [2:0] irq;
  logic       at_max;
  logic       at_bottom;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tmr_dual_cmp i_tmr_dual_cmp (
    .clk(clk), .rst(rst), .tick(tick), .host_we(host_we),
    .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .irq_ack(irq_ack), .irq(irq), .at_max(at_max), .at_bottom(at_bottom)
  );

  // {we, addr[2:0], wdata[7:0], tick, expected count[7:0]}
  localparam int NV = 13;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 3'd3, 8'hE1, 1'b0, 8'h00},  // R3 up, run
    {1'b0, 3'd0, 8'h00, 1'b1, 8'h01},  // R3
    {1'b0, 3'd0, 8'h00, 1'b1, 8'h02},  // R3
    {1'b1, 3'd0, 8'hFE, 1'b0, 8'hFE},
    {1'b0, 3'd0, 8'h00, 1'b1, 8'hFF},
    {1'b0, 3'd0, 8'h00, 1'b1, 8'h00},  // R3 wrap
    {1'b1, 3'd3, 8'hE0, 1'b0, 8'h00},  // R2 stop
    {1'b0, 3'd0, 8'h00, 1'b1, 8'h00},  // R2 tick ignored
    {1'b1, 3'd0, 8'h55, 1'b0, 8'h55},  // R2 write while stopped
    {1'b1, 3'd3, 8'hE9, 1'b0, 8'h55},  // R4 down
    {1'b0, 3'd0, 8'h00, 1'b1, 8'h54},  // R4
    {1'b1, 3'd0, 8'h00, 1'b0, 8'h00},
    {1'b0, 3'd0, 8'h00, 1'b1, 8'hFF}   // R4 wrap
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                      input logic tk, input logic [2:0] ack);
    @(negedge clk);
    host_we = we; host_waddr = a; host_wdata = d; tick = tk; irq_ack = ack;
    @(negedge clk);
    host_we = 1'b0; tick = 1'b0; irq_ack = 3'b000;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 3'b000);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    host_raddr = a;
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    rst = 1'b1; tick = 1'b0; host_we = 1'b0; host_waddr = '0;
    host_wdata = '0; host_raddr = '0; irq_ack = '0;
    do_reset();

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 reg after reset", v, 8'h00);
    end
    chk("R1 at_bottom", {7'd0, at_bottom}, 8'h01);
    chk("R1 at_max", {7'd0, at_max}, 8'h00);
    chk("R1 irq", {5'd0, irq}, 8'h00);

    // Vector walk: count sequences for R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][20], VEC[i][19:17], VEC[i][16:9], VEC[i][8], 3'b000);
      rd(3'd0, v);
      chk($sformatf("R2/R3/R4 vector %0d", i), v, VEC[i][7:0]);
    end
    rd(3'd3, v);
    chk("R13 ctrl readback", v, 8'hE9);

    // Reset mid-run clears everything again
    do_reset();
    rd(3'd0, v); chk("R1 count after second reset", v, 8'h00);
    rd(3'd4, v); chk("R1 flags after second reset", v, 8'h00);

    // R7 timing: equality alone does not set; running tick does
    wr(3'd2, 8'h10);
    wr(3'd0, 8'h10);
    rd(3'd4, v); chk("R7 no flag without tick", v, 8'h00);
    wr(3'd3, 8'h01);
    rd(3'd0, v); chk("R3 holds without tick", v, 8'h10);
    rd(3'd4, v); chk("R7 no flag before running tick", v, 8'h00);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'b000);
    rd(3'd0, v); chk("R3 count after tick", v, 8'h11);
    rd(3'd4, v); chk("R7 flag B set", v, 8'h02);
    chk("R8 irq masked", {5'd0, irq}, 8'h00);
    wr(3'd3, 8'h41);
    chk("R8 irq B enabled", {5'd0, irq}, 8'h02);

    // R9 clear paths
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R9 write zero keeps flag", v, 8'h02);
    step(1'b0, 3'd0, 8'h00, 1'b0, 3'b010);
    rd(3'd4, v); chk("R9 ack clears flag B", v, 8'h00);
    chk("R9 irq drops", {5'd0, irq}, 8'h00);

    // R10 set beats same-cycle write-one clear
    wr(3'd0, 8'h10);
    step(1'b1, 3'd4, 8'h02, 1'b1, 3'b000);
    rd(3'd4, v); chk("R10 set wins", v, 8'h02);
    rd(3'd0, v); chk("R10 count stepped", v, 8'h11);
    wr(3'd4, 8'h02);
    rd(3'd4, v); chk("R9 write one clears", v, 8'h00);

    // R6 write beats tick
    step(1'b1, 3'd0, 8'h80, 1'b1, 3'b000);
    rd(3'd0, v); chk("R6 write wins over tick", v, 8'h80);

    // R5 clear on compare A
    wr(3'd1, 8'h82);
    wr(3'd3, 8'h11);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'b000);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'b000);
    rd(3'd0, v); chk("R5 approach A", v, 8'h82);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'b000);
    rd(3'd0, v); chk("R5 cleared on A", v, 8'h00);
    rd(3'd4, v); chk("R7 flag A set", v, 8'h01);

    // R5 hold mode
    wr(3'd3, 8'h19);
    wr(3'd0, 8'h44);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'b000);
    rd(3'd0, v); chk("R5 hold mode clears", v, 8'h00);

    // R4 down wrap sets overflow, R11 at_max
    wr(3'd4, 8'h07);
    wr(3'd3, 8'h09);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'b000);
    rd(3'd0, v); chk("R4 down wrap", v, 8'hFF);
    rd(3'd4, v); chk("R4 overflow flag", v, 8'h04);
    chk("R11 at_max", {6'd0, at_max, at_bottom}, 8'h02);
    wr(3'd3, 8'h89);
    chk("R8 irq overflow", {5'd0, irq}, 8'h04);
    step(1'b0, 3'd0, 8'h00, 1'b0, 3'b100);
    rd(3'd4, v); chk("R9 ack overflow", v, 8'h00);

    // R12 up wrap sets overflow
    wr(3'd3, 8'h01);
    step(1'b0, 3'd0, 8'h00, 1'b1, 3'b000);
    rd(3'd4, v); chk("R12 up wrap overflow", v, 8'h04);
    chk("R11 at_bottom", {6'd0, at_max, at_bottom}, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule